// File: doc/BRIEF.md
# Immediate Codec Command Port

This block gives software a direct, one-at-a-time path for sending a single command word to an attached codec and collecting its 32-bit answer, without setting up any command or response rings. Software sees three registers on a simple write/read register port: a command register, a response register and a status register that holds a busy flag and a response-valid flag.

The usual flow is as follows. Software waits for busy to read 0 and writes 1 to the valid flag to discard any old answer. It then loads the command register and writes 1 to busy. The block holds a request toward the codec, with the stored command, until the codec acknowledges it with its reply. In the cycle of that acknowledge, the block stores the reply, drops busy and raises valid. Software polls valid and then reads the response register. The command word uses the same field layout as the ring engine: codec address in bits 31:28, a direct flag in bit 27, node id in bits 26:20, verb in bits 19:8 and payload in bits 7:0. The port only carries the word and does not decode it.

Top module: `imm_cmd_port`

## Requirements
- R1: After reset the command, response and status registers read 0 and `link_req` is low.
- R2: The register port decodes offset 0 as the command register, offset 1 as the response register and offset 2 as the status register. Offset 3 reads 0. A command write made while busy is 0 is stored and can be read back unchanged.
- R3: A write to status (offset 2) with bit 0 set while busy is 0 sets busy (status bit 0) at the next clock edge. From that edge `link_req` is high and `link_cmd` carries the stored command word.
- R4: A command register write made while busy is 1 is ignored. Both the readback and `link_cmd` keep the command that was launched.
- R5: Writing status with bit 0 cleared has no effect on busy. Only a codec acknowledge clears busy.
- R6: At the clock edge where `link_ack` is high while busy is 1, the block captures `link_resp` into the response register, clears busy, sets valid (status bit 1) and drops `link_req`, all at that one edge.
- R7: Writing status with bit 1 set clears valid. Writing status with bit 1 cleared leaves valid unchanged.
- R8: When a valid-clearing status write and a codec acknowledge land on the same edge, valid ends up set and the new reply is held.
- R9: A `link_ack` that arrives while busy is 0 leaves the response register and the status register unchanged.
- R10: A single status write with both bit 0 and bit 1 set, made while idle with valid set, clears valid and sets busy at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (2) | Register offset for both writes and reads |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr` (combinational by default) |
| link_req | output | 1 | Command pending toward the codec |
| link_cmd | output | DATA_W (32) | Command word presented to the codec |
| link_ack | input | 1 | Codec acknowledge, one cycle, carrying the reply |
| link_resp | input | DATA_W (32) | Codec reply word, sampled with `link_ack` |

## Verification
The embedded properties assume the codec raises `link_ack` only in response to a pending request and holds it for one cycle. They also assume the register port issues at most one write per cycle. The bench's codec model follows this: it waits for `link_req`, waits a chosen number of cycles and then pulses the acknowledge once. Two directed cases break that pattern on purpose. One drives a stray acknowledge while idle, and one lines an acknowledge up with a valid-clearing write. Both are still legal single-cycle pulses, so the properties continue to hold.

// File: rtl/imm_pkg.sv
package imm_pkg;
   // status register bit positions, decoded by software
   localparam int ST_BUSY  = 0;
   localparam int ST_VALID = 1;

   // command word field layout shared with the ring engine
   localparam int CW_CAD_LSB  = 28;
   localparam int CW_DIR_BIT  = 27;
   localparam int CW_NODE_LSB = 20;
   localparam int CW_VERB_LSB = 8;

   function automatic logic [31:0] pack_cmd(input logic [3:0]  cad,
                                            input logic        dir,
                                            input logic [6:0]  node,
                                            input logic [11:0] verb,
                                            input logic [7:0]  arg);
      logic [31:0] w;
      w = '0;
      w[CW_CAD_LSB +: 4]   = cad;
      w[CW_DIR_BIT]        = dir;
      w[CW_NODE_LSB +: 7]  = node;
      w[CW_VERB_LSB +: 12] = verb;
      w[7:0]               = arg;
      return w;
   endfunction
endpackage

// File: rtl/imm_cmd_hold.sv
module imm_cmd_hold #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              busy_i,
   output logic [DATA_W-1:0] cmd_o
);
   logic [DATA_W-1:0] cmd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cmd_q <= '0;
      else if (wr_i && !busy_i)
         cmd_q <= wdata_i;
   end

   assign cmd_o = cmd_q;

   // command word frozen while a launch is outstanding
   assert_cmd_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable(cmd_o));
endmodule

// File: rtl/imm_handshake.sv
module imm_handshake #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_wr_i,
   input  logic              go_i,
   input  logic              clr_i,
   input  logic              link_ack_i,
   input  logic [DATA_W-1:0] link_resp_i,
   output logic              busy_o,
   output logic              valid_o,
   output logic [DATA_W-1:0] resp_o
);
   logic              busy_q, valid_q;
   logic [DATA_W-1:0] resp_q;
   logic              done, launch;

   assign done   = busy_q & link_ack_i;
   assign launch = stat_wr_i & go_i & ~busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         valid_q <= 1'b0;
         resp_q  <= '0;
      end else begin
         if (done)
            busy_q <= 1'b0;
         else if (launch)
            busy_q <= 1'b1;

         if (done)
            valid_q <= 1'b1;
         else if (stat_wr_i && clr_i)
            valid_q <= 1'b0;

         if (done)
            resp_q <= link_resp_i;
      end
   end

   assign busy_o  = busy_q;
   assign valid_o = valid_q;
   assign resp_o  = resp_q;

   assert_launch_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && stat_wr_i && go_i) |=> busy_o);

   assert_busy_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !link_ack_i) |=> busy_o);

   assert_done_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && link_ack_i) |=> (!busy_o && valid_o));

   assert_done_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && link_ack_i && stat_wr_i && clr_i) |=> valid_o);

   assert_resp_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && link_ack_i) |=> $stable(resp_o));
endmodule

// File: rtl/imm_rd_path.sv
module imm_rd_path #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 2,
   parameter int CMD_OFS   = 0,
   parameter int RESP_OFS  = 1,
   parameter int STAT_OFS  = 2,
   parameter bit READ_PIPE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] cmd_i,
   input  logic [DATA_W-1:0] resp_i,
   input  logic              busy_i,
   input  logic              valid_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(CMD_OFS);
   localparam logic [ADDR_W-1:0] A_RESP = ADDR_W'(RESP_OFS);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

   logic [DATA_W-1:0] stat_word, mux;

   always_comb begin
      stat_word = '0;
      stat_word[imm_pkg::ST_BUSY]  = busy_i;
      stat_word[imm_pkg::ST_VALID] = valid_i;
   end

   always_comb begin
      if (addr_i == A_CMD)       mux = cmd_i;
      else if (addr_i == A_RESP) mux = resp_i;
      else if (addr_i == A_STAT) mux = stat_word;
      else                       mux = '0;
   end

   generate
      if (READ_PIPE) begin : g_pipe
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= mux;
         end
         assign rdata_o = rd_q;
      end else begin : g_comb
         assign rdata_o = mux;
      end
   endgenerate
endmodule

// File: rtl/imm_cmd_port.sv
module imm_cmd_port #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 2,
   parameter int CMD_OFS   = 0,
   parameter int RESP_OFS  = 1,
   parameter int STAT_OFS  = 2,
   parameter bit READ_PIPE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              link_req,
   output logic [DATA_W-1:0] link_cmd,
   input  logic              link_ack,
   input  logic [DATA_W-1:0] link_resp
);
   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(CMD_OFS);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

   generate
      if (DATA_W < 32) begin : g_bad_width
         $error("DATA_W must hold a full command word");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W too small for three registers");
      end
      if (CMD_OFS == RESP_OFS || CMD_OFS == STAT_OFS || RESP_OFS == STAT_OFS) begin : g_bad_map
         $error("register offsets must differ");
      end
   endgenerate

   logic              cmd_wr, stat_wr, busy, valid;
   logic [DATA_W-1:0] cmd_word, resp_word;

   assign cmd_wr  = reg_wr && (reg_addr == A_CMD);
   assign stat_wr = reg_wr && (reg_addr == A_STAT);

   imm_cmd_hold #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (cmd_wr),
      .wdata_i (reg_wdata),
      .busy_i  (busy),
      .cmd_o   (cmd_word)
   );

   imm_handshake #(.DATA_W(DATA_W)) u_hs (
      .clk         (clk),
      .rst_n       (rst_n),
      .stat_wr_i   (stat_wr),
      .go_i        (reg_wdata[imm_pkg::ST_BUSY]),
      .clr_i       (reg_wdata[imm_pkg::ST_VALID]),
      .link_ack_i  (link_ack),
      .link_resp_i (link_resp),
      .busy_o      (busy),
      .valid_o     (valid),
      .resp_o      (resp_word)
   );

   imm_rd_path #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS),
      .RESP_OFS(RESP_OFS), .STAT_OFS(STAT_OFS), .READ_PIPE(READ_PIPE)
   ) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (reg_addr),
      .cmd_i   (cmd_word),
      .resp_i  (resp_word),
      .busy_i  (busy),
      .valid_i (valid),
      .rdata_o (reg_rdata)
   );

   assign link_req = busy;
   assign link_cmd = cmd_word;

   assert_req_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (link_req && link_ack) |=> !link_req);

   assert_req_cmd_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (link_req && !link_ack) |=> (link_req && $stable(link_cmd)));
endmodule

// File: tb/imm_cmd_port_bench.sv
`timescale 1ns/1ps
module imm_cmd_port_bench;
   localparam logic [31:0] KEY = 32'hA5C3_0F69;
   localparam logic [1:0]  O_CMD = 2'd0, O_RESP = 2'd1, O_STAT = 2'd2, O_NONE = 2'd3;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        link_req, link_ack = 1'b0;
   logic [31:0] link_cmd, link_resp = '0;

   int errors = 0, checks = 0;
   bit auto_on = 1'b1;
   int ack_dly = 2;
   logic [31:0] exp_q[$];

   always #2.5 clk = ~clk;

   imm_cmd_port u_imm_cmd_port (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_req(link_req),
      .link_cmd(link_cmd), .link_ack(link_ack), .link_resp(link_resp)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   // driver: queue the word the codec must see, then launch
   task automatic launch(input logic [31:0] c);
      wr(O_CMD, c);
      exp_q.push_back(c);
      wr(O_STAT, 32'h1);
   endtask

   task automatic wait_valid();
      logic [31:0] s;
      for (int i = 0; i < 200; i++) begin
         rd(O_STAT, s);
         if (s[1]) break;
         @(negedge clk);
      end
   endtask

   // monitor / codec model: pops the expected command and replies
   initial begin
      forever begin
         @(negedge clk);
         if (auto_on && link_req) begin
            if (exp_q.size() == 0) chk("R3 unexpected request", link_cmd, 32'hx);
            else chk("R3 link_cmd", link_cmd, exp_q.pop_front());
            repeat (ack_dly) @(negedge clk);
            link_resp = link_cmd ^ KEY;
            link_ack  = 1'b1;
            @(negedge clk);
            link_ack  = 1'b0;
         end
      end
   end

   initial begin
      #200000;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] v, c1, c2, c3, c4;
      c1 = imm_pkg::pack_cmd(4'h2, 1'b0, 7'h11, 12'hF00, 8'h04);
      c2 = imm_pkg::pack_cmd(4'h0, 1'b1, 7'h7F, 12'h705, 8'hC3);
      c3 = imm_pkg::pack_cmd(4'hF, 1'b0, 7'h01, 12'h3A0, 8'hFF);
      c4 = 32'h1234_5678;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      rd(O_STAT, v); chk("R1 status", v, 32'h0);
      rd(O_RESP, v); chk("R1 response", v, 32'h0);
      rd(O_CMD, v);  chk("R1 command", v, 32'h0);
      chk("R1 link_req", {31'b0, link_req}, 32'h0);

      // basic launch and completion
      ack_dly = 2;
      launch(c1);
      rd(O_STAT, v); chk("R3 busy after launch", v, 32'h1);
      chk("R3 link_req", {31'b0, link_req}, 32'h1);
      wait_valid();
      rd(O_STAT, v); chk("R6 status after reply", v, 32'h2);
      rd(O_RESP, v); chk("R6 response", v, c1 ^ KEY);
      chk("R6 link_req dropped", {31'b0, link_req}, 32'h0);

      // valid clear rules
      wr(O_STAT, 32'h0); rd(O_STAT, v); chk("R7 write 0 keeps valid", v, 32'h2);
      wr(O_STAT, 32'h2); rd(O_STAT, v); chk("R7 write 1 clears valid", v, 32'h0);

      // writes while busy
      ack_dly = 8;
      launch(c2);
      wr(O_CMD, c3);
      rd(O_CMD, v); chk("R4 command readback while busy", v, c2);
      chk("R4 link_cmd while busy", link_cmd, c2);
      wr(O_STAT, 32'h0);
      rd(O_STAT, v); chk("R5 busy kept after write 0", v, 32'h1);
      wait_valid();
      rd(O_RESP, v); chk("R6 response second", v, c2 ^ KEY);

      // clear and launch in one write
      ack_dly = 3;
      wr(O_CMD, c3);
      exp_q.push_back(c3);
      wr(O_STAT, 32'h3);
      rd(O_STAT, v); chk("R10 busy set valid cleared", v, 32'h1);
      wait_valid();
      rd(O_RESP, v); chk("R10 response", v, c3 ^ KEY);

      // stray acknowledge while idle
      auto_on = 1'b0;
      @(negedge clk);
      link_resp = 32'hDEAD_BEEF; link_ack = 1'b1;
      @(negedge clk);
      link_ack = 1'b0;
      rd(O_RESP, v); chk("R9 response untouched", v, c3 ^ KEY);
      rd(O_STAT, v); chk("R9 status untouched", v, 32'h2);

      // clear write colliding with completion
      wr(O_CMD, c4);
      wr(O_STAT, 32'h1);
      rd(O_STAT, v); chk("R3 busy with valid still set", v, 32'h3);
      chk("R3 link_cmd manual", link_cmd, c4);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = O_STAT; reg_wdata = 32'h2;
      link_resp = 32'h0BAD_F00D; link_ack = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; link_ack = 1'b0;
      rd(O_STAT, v); chk("R8 valid wins over clear", v, 32'h2);
      rd(O_RESP, v); chk("R8 new reply held", v, 32'h0BAD_F00D);

      // register map and command patterns
      wr(O_CMD, 32'hFFFF_FFFF); rd(O_CMD, v); chk("R2 all ones", v, 32'hFFFF_FFFF);
      wr(O_CMD, 32'h0);         rd(O_CMD, v); chk("R2 all zeros", v, 32'h0);
      wr(O_CMD, c2);            rd(O_CMD, v); chk("R2 field pattern", v, c2);
      rd(O_NONE, v); chk("R2 unused offset", v, 32'h0);
      chk("R3 queue drained", exp_q.size(), 32'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule